// File: doc/BRIEF.md
# Asynchronous SRAM Write Controller

This block streams data words into an external asynchronous static RAM. A producer raises `dv` and presents a word on `din`; the controller latches the word, drives it out on `dout` together with the target address, and produces the active-low chip-enable and write-enable strobes. The memory performs its write during the interval in which both `ce_n` and `we_n` are low. The output-enable strobe `oe_n` is held inactive throughout, because the block never reads.

Each write takes two clock cycles. In the pulse cycle, `ce_n` and `we_n` are both low while address and data are stable. In the recovery cycle, `we_n` is high again, `ce_n` is still low, and address and data are held. This gives the memory setup and hold margin around every write pulse. Words go to consecutive addresses. The address starts at zero and wraps after `DEPTH-1`. All outputs come from registers clocked on the rising edge.

The state machine has three states. `ST_IDLE` has all strobes high. `ST_STROBE` is the write pulse. `ST_RECOVER` raises `we_n`. The transitions are:
- `idle_to_strobe`: taken when `dv` is high in `ST_IDLE`.
- `strobe_to_recover`: always taken.
- `recover_to_strobe`: taken when `dv` is still high.
- `recover_to_idle`: taken when `dv` is low.

Reset is synchronous and returns the machine to `ST_IDLE` from any state.

Top module: `sram_write_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `ce_n`=1, `we_n`=1, `oe_n`=1 and `addr`=0, and the state is `ST_IDLE`.
- R2: `oe_n` is 1 in every cycle.
- R3: In `ST_IDLE`, `dv`=1 at a rising edge drives `ce_n`=0 and `we_n`=0 after that edge. `dout` then equals the `din` value sampled at that same edge.
- R4: A write pulse lasts exactly one clock. A cycle with `we_n`=0 is always followed by a cycle with `we_n`=1 and `ce_n`=0.
- R5: `addr` and `dout` do not change between the pulse cycle and the recovery cycle that follows it.
- R6: `addr` rises by one at the edge that ends each recovery cycle.
- R7: After the write to address `DEPTH-1` completes, the next address is 0.
- R8: If `dv`=0 at the edge that ends a recovery cycle, `ce_n` and `we_n` are both 1 afterwards. The value of `dv` during the pulse cycle is ignored, and the write in progress always completes.
- R9: `we_n` is never 0 while `ce_n` is 1.
- R10: If `dv`=1 at the edge that ends a recovery cycle, a new pulse follows at once. A held `dv` therefore gives one write every two cycles, and each write stores the word sampled at its own start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dv | input | 1 | Data valid; a word is accepted while high |
| din | input | DW | Word to be written |
| addr | output | AW | Memory address |
| oe_n | output | 1 | Output enable, active low, held high |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable, active low |
| dout | output | DW | Data bus driven to the memory |

## Verification
Strobes, data and address are all registered, so every response appears one edge after the `dv` and `din` values that cause it. This holds for the start of a pulse, its end, the release to idle and the address step. The bench keeps a phase, address and data model that it advances at the same rising edge as the design, using the inputs it applied half a period earlier. It compares the ports at the following falling edge, when both sides have settled. A behavioural memory in the bench records `dout` at `addr` whenever both strobes are low. Its contents are compared with the model after an exhaustive sweep of six-cycle `dv` patterns, several of which cross the address wrap.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic oe_n;
        logic ce_n;
        logic we_n;
    } strobe_t;

    // Strobe levels that each state presents to the memory.
    function automatic strobe_t strobe_for(input wr_state_e st);
        strobe_t s;
        s.oe_n = 1'b1;
        unique case (st)
            ST_IDLE:    begin s.ce_n = 1'b1; s.we_n = 1'b1; end
            ST_STROBE:  begin s.ce_n = 1'b0; s.we_n = 1'b0; end
            ST_RECOVER: begin s.ce_n = 1'b0; s.we_n = 1'b1; end
            default:    begin s.ce_n = 1'b1; s.we_n = 1'b1; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dv,
    output wr_state_e next_state,
    output logic      accept,
    output logic      advance
);

    wr_state_e state;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state;
    end

    // Transition logic
    always_comb begin
        next_state = state;
        accept     = 1'b0;
        advance    = 1'b0;
        if (rst) begin
            next_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (dv) begin
                        next_state = ST_STROBE;   // idle_to_strobe
                        accept     = 1'b1;
                    end
                end
                ST_STROBE: begin
                    next_state = ST_RECOVER;      // strobe_to_recover
                end
                ST_RECOVER: begin
                    advance = 1'b1;
                    if (dv) begin
                        next_state = ST_STROBE;   // recover_to_strobe
                        accept     = 1'b1;
                    end else begin
                        next_state = ST_IDLE;     // recover_to_idle
                    end
                end
                default: next_state = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_wr_addr.sv
module sram_wr_addr #(
    parameter int AW    = 16,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (advance) addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end

endmodule

// File: rtl/sram_wr_outreg.sv
module sram_wr_outreg
    import sram_wr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_state_e     next_state,
    input  logic          accept,
    input  logic [DW-1:0] din,
    output logic          oe_n,
    output logic          ce_n,
    output logic          we_n,
    output logic [DW-1:0] dout
);

    strobe_t nxt;

    always_comb nxt = strobe_for(next_state);

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n <= 1'b1;
            ce_n <= 1'b1;
            we_n <= 1'b1;
            dout <= '0;
        end else begin
            oe_n <= nxt.oe_n;
            ce_n <= nxt.ce_n;
            we_n <= nxt.we_n;
            if (accept) dout <= din;
        end
    end

endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
    import sram_wr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dv,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr,
    output logic          oe_n,
    output logic          ce_n,
    output logic          we_n,
    output logic [DW-1:0] dout
);

    wr_state_e next_state;
    logic      accept;
    logic      advance;

    sram_wr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dv         (dv),
        .next_state (next_state),
        .accept     (accept),
        .advance    (advance)
    );

    sram_wr_addr #(.AW(AW), .DEPTH(DEPTH)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .addr    (addr)
    );

    sram_wr_outreg #(.DW(DW)) u_out (
        .clk        (clk),
        .rst        (rst),
        .next_state (next_state),
        .accept     (accept),
        .din        (din),
        .oe_n       (oe_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .dout       (dout)
    );

endmodule

// File: rtl/sram_write_ctrl_chk.sv
module sram_write_ctrl_chk #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 1 << AW
) (
    input logic          clk,
    input logic          rst,
    input logic          dv,
    input logic [DW-1:0] din,
    input logic [AW-1:0] addr,
    input logic          oe_n,
    input logic          ce_n,
    input logic          we_n,
    input logic [DW-1:0] dout
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic unused_din;
    assign unused_din = ^din;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ce_n && we_n && oe_n && addr == '0));

    a_r2_oe_high: assert property (@(posedge clk) disable iff (rst)
        oe_n);

    a_r3_start: assert property (@(posedge clk) disable iff (rst)
        (ce_n && dv) |=> (!ce_n && !we_n && dout == $past(din)));

    a_r4_one_clock_pulse: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> (we_n && !ce_n));

    a_r5_stable_around_pulse: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> ($stable(addr) && $stable(dout)));

    a_r6_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n) |=>
            (addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1)));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n && !dv) |=> (ce_n && we_n));

    a_r9_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);

    a_r10_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n && dv) |=> (!we_n && dout == $past(din)));

endmodule

bind sram_write_ctrl sram_write_ctrl_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sram_write_ctrl_tb.sv
module sram_write_ctrl_tb;

    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int DEPTH = 6;
    localparam int WATCHDOG = 50000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dv  = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] addr;
    logic          oe_n, ce_n, we_n;
    logic [DW-1:0] dout;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // Reference model: 0 idle, 1 pulse, 2 recovery
    int            m_ph   = 0;
    int            m_addr = 0;
    logic [DW-1:0] m_data = '0;
    logic [DW-1:0] exp_mem [DEPTH];
    logic [DW-1:0] obs_mem [DEPTH];

    always #2 clk = ~clk;   // 250 MHz

    sram_write_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .dv(dv), .din(din), .addr(addr),
        .oe_n(oe_n), .ce_n(ce_n), .we_n(we_n), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Model advance at the same edge as the design
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ph = 0; m_addr = 0;
        end else begin
            case (m_ph)
                0: if (dv) begin
                       m_ph = 1; m_data = din; exp_mem[m_addr] = din;
                   end
                1: m_ph = 2;
                default: begin
                    m_addr = (m_addr == DEPTH - 1) ? 0 : m_addr + 1;
                    if (dv) begin
                        m_ph = 1; m_data = din; exp_mem[m_addr] = din;
                    end else m_ph = 0;
                end
            endcase
        end
    end

    // Port comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && cycles > 0 && !done) begin
            check(oe_n == 1'b1, "R2 oe_n", int'(oe_n), 1);
            check(ce_n == (m_ph == 0), "R3/R8 ce_n", int'(ce_n), int'(m_ph == 0));
            check(we_n == (m_ph != 1), "R4/R10 we_n", int'(we_n), int'(m_ph != 1));
            check(!(ce_n && !we_n), "R9 we_n inside ce_n", int'(we_n), 1);
            check(int'(addr) == m_addr, "R6/R7 addr", int'(addr), m_addr);
            if (m_ph != 0)
                check(dout == m_data, "R3/R5 dout", int'(dout), int'(m_data));
            if (!ce_n && !we_n) obs_mem[addr] = dout;
        end
    end

    task automatic step(input bit v);
        @(negedge clk);
        #1;
        dv  = v;
        din = DW'($urandom_range(0, 255));
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1'b1; dv = 1'b1;
        @(negedge clk);
        check(ce_n && we_n && oe_n, "R1 strobes in reset", int'({oe_n, ce_n, we_n}), 7);
        check(addr == '0, "R1 addr in reset", int'(addr), 0);
        #1; rst = 1'b0; dv = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles >= WATCHDOG);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = '0; obs_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        #1; rst = 1'b0;
        @(negedge clk);
        check(ce_n && we_n && addr == '0, "R1 state after reset", int'({ce_n, we_n}), 3);

        // Exhaustive six-cycle dv patterns, each followed by idle time (R3, R8, R10)
        for (int p = 0; p < 64; p++) begin
            for (int b = 0; b < 6; b++) step(p[b]);
            repeat (3) step(1'b0);
        end

        // Long held dv: back-to-back writes across the wrap (R7, R10)
        repeat (4 * DEPTH + 3) step(1'b1);
        repeat (3) step(1'b0);

        for (int i = 0; i < DEPTH; i++)
            check(obs_mem[i] == exp_mem[i], "R3/R10 memory contents",
                  int'(obs_mem[i]), int'(exp_mem[i]));

        // Reset in the middle of a write (R1)
        step(1'b1); step(1'b1);
        do_reset();
        repeat (4) step(1'b0);
        step(1'b1); step(1'b0); repeat (3) step(1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule